// File: doc/BRIEF.md
# Byte-Parity SRAM Guard

This block wraps a word-wide SRAM and stores one parity bit beside each data byte, so every stored word is 36 bits wide. Each parity bit is the even parity of its byte folded together with an address term, the XOR of all word-index bits. A word that is read back at a location other than the one it was written to is therefore likely to show a mismatch. Writes may cover one byte, two bytes or the whole word. Only those byte lanes are written, together with their parity bits. Every read fetches the whole word and checks all four lanes. Only words whose index is below a configurable boundary are checked. Words above the boundary never report errors.

A detected error gives a one-cycle pulse on the non-maskable interrupt output. When the lock input is high, the same pulse appears on a timer-break output. The error also sets a sticky flag, which software clears by writing one to it. A bypass input removes the address term from the parity, both when it is generated and when it is checked. This lets code that runs through a low alias address read back without false alarms.

Reads are handled by a two-state machine. The machine is in ST_IDLE when no read response is due. The transition IDLE->RESP is taken on an accepted read. The transition RESP->RESP is taken on a back-to-back read. The transition RESP->IDLE is taken when the cycle holds no read. Read data, `rvalid`, the interrupt pulse and the break output are all registered, so they appear one cycle after the request.

Top module: `par_sram_guard`

## Requirements
- R1: After reset, `rvalid`, `err_nmi`, `err_brk` and `err_flag` are low, and every word reads as zero without an error when checking is on and bypass is off.
- R2: A read accepted at a clock edge (`req`=1, `we`=0) drives `rvalid` high for exactly one cycle after that edge, with the word on `rdata`. Write cycles and idle cycles give `rvalid`=0.
- R3: `size`=0 writes the byte lane `addr[1:0]`. `size`=1 writes lanes 2*`addr[1]` and 2*`addr[1]`+1. `size`=2 or 3 writes all four lanes. Lane k always takes `wdata[8k+7:8k]`, and lanes that are not written keep their contents.
- R4: A word written and then read with the same `bypass` value never reports an error.
- R5: With checking on and the word inside the region, a read with a `bypass` value that differs from the write pulses `err_nmi` in the `rvalid` cycle if the word index has an odd number of one bits. It does not pulse if that number is even.
- R6: A read with `chk_en`=0 never pulses `err_nmi` or `err_brk` and never sets `err_flag`.
- R7: Reads of word indices at or above `PROT_WORDS` never report an error.
- R8: `err_flag` rises in the same cycle as `err_nmi` and stays high until a `clr_flag` cycle. It clears after that cycle, unless an error is detected in the same cycle; the new error wins.
- R9: `err_brk` repeats `err_nmi` when `lock` was high with the read request, and stays low otherwise.
- R10: A partial write refreshes only the parity of the lanes it writes. An error caused by a mismatched address term therefore persists until every lane has been rewritten under the current `bypass` setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req | input | 1 | Access request this cycle |
| we | input | 1 | 1 = write, 0 = read |
| size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| addr | input | IDX_W+2 | Byte address |
| wdata | input | 32 | Write data, lane positioned |
| chk_en | input | 1 | Enable parity checking on reads |
| bypass | input | 1 | Drop the address term from parity |
| lock | input | 1 | Route errors to the break output |
| clr_flag | input | 1 | Write-one-to-clear of the sticky flag |
| rdata | output | 32 | Read data |
| rvalid | output | 1 | Read data valid |
| err_nmi | output | 1 | One-cycle parity error pulse |
| err_brk | output | 1 | Parity error routed to timer break |
| err_flag | output | 1 | Sticky parity error flag |

## Verification
A stored parity bit written with the wrong lane or address term stays hidden until that word is read. It then shows up as a false or missing `err_nmi` pulse in the `rvalid` cycle, one cycle after the request. For this reason the bench writes and reads back every word under all four combinations of write and read bypass. It also sweeps every size and offset, then checks data and error on the next read. A wrong flag or state register shows at `err_flag` or `rvalid` on the very next sample.

// File: rtl/par_sram_pkg.sv
package par_sram_pkg;
    localparam int LANES  = 4;
    localparam int LANE_W = 8;
    localparam int WORD_W = LANES * LANE_W;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_WIDE = 2'd3
    } acc_size_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } rsp_state_e;

    function automatic logic [LANES-1:0] lane_mask(acc_size_e sz, logic [1:0] off);
        logic [LANES-1:0] m;
        unique case (sz)
            SZ_BYTE: m = 4'b0001 << off;
            SZ_HALF: m = off[1] ? 4'b1100 : 4'b0011;
            default: m = 4'b1111;
        endcase
        return m;
    endfunction
endpackage

// File: rtl/par_lane_gen.sv
module par_lane_gen #(
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input  logic [LANES*LANE_W-1:0] data,
    input  logic                    term,
    output logic [LANES-1:0]        par
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign par[g] = (^data[g*LANE_W +: LANE_W]) ^ term;
    end
endmodule

// File: rtl/par_ram_store.sv
module par_ram_store #(
    parameter int IDX_W  = 4,
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [IDX_W-1:0]        wr_idx,
    input  logic [LANES-1:0]        wr_lanes,
    input  logic [LANES*LANE_W-1:0] wr_data,
    input  logic [LANES-1:0]        wr_par,
    input  logic [IDX_W-1:0]        rd_idx,
    output logic [LANES*LANE_W-1:0] rd_data,
    output logic [LANES-1:0]        rd_par
);
    localparam int DEPTH = 1 << IDX_W;

    logic [LANES*LANE_W-1:0] data_mem [DEPTH];
    logic [LANES-1:0]        par_mem  [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int w = 0; w < DEPTH; w++) begin
                data_mem[w] <= '0;
                par_mem[w]  <= {LANES{^(IDX_W'(w))}};
            end
        end else if (wr_en) begin
            for (int k = 0; k < LANES; k++) begin
                if (wr_lanes[k]) begin
                    data_mem[wr_idx][k*LANE_W +: LANE_W] <= wr_data[k*LANE_W +: LANE_W];
                    par_mem[wr_idx][k]                   <= wr_par[k];
                end
            end
        end
    end

    assign rd_data = data_mem[rd_idx];
    assign rd_par  = par_mem[rd_idx];
endmodule

// File: rtl/par_err_track.sv
module par_err_track (
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic clr,
    output logic flag
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag <= 1'b0;
        else        flag <= hit | (flag & ~clr);
    end

    // R8: a detected error always leaves the flag set
    p_hit_sets_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> flag);
    // R8: without a clear the flag is held
    p_flag_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr) |=> flag);
    // R8: a clear with no error drops the flag
    p_clear_drops_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !hit) |=> !flag);
endmodule

// File: rtl/par_sram_guard.sv
module par_sram_guard
    import par_sram_pkg::*;
#(
    parameter int IDX_W      = 4,
    parameter int PROT_WORDS = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req,
    input  logic               we,
    input  logic [1:0]         size,
    input  logic [IDX_W+1:0]   addr,
    input  logic [WORD_W-1:0]  wdata,
    input  logic               chk_en,
    input  logic               bypass,
    input  logic               lock,
    input  logic               clr_flag,
    output logic [WORD_W-1:0]  rdata,
    output logic               rvalid,
    output logic               err_nmi,
    output logic               err_brk,
    output logic               err_flag
);
    logic [IDX_W-1:0]  word_idx;
    logic [1:0]        lane_off;
    logic              addr_term;
    logic [LANES-1:0]  wr_lanes;
    logic [LANES-1:0]  wr_par;
    logic [LANES-1:0]  chk_par;
    logic [LANES-1:0]  st_par;
    logic [WORD_W-1:0] st_data;
    logic              rd_acc;
    logic              wr_acc;
    logic              in_region;
    logic              hit_now;

    rsp_state_e        state_q, state_d;
    logic [WORD_W-1:0] rdata_q;
    logic              hit_q;
    logic              lock_q;

    assign word_idx  = addr[IDX_W+1:2];
    assign lane_off  = addr[1:0];
    assign addr_term = bypass ? 1'b0 : ^word_idx;
    assign wr_lanes  = lane_mask(acc_size_e'(size), lane_off);
    assign rd_acc    = req & ~we;
    assign wr_acc    = req & we;
    assign in_region = int'(word_idx) < PROT_WORDS;

    par_lane_gen #(.LANES(LANES), .LANE_W(LANE_W)) u_wgen (
        .data(wdata), .term(addr_term), .par(wr_par)
    );

    par_ram_store #(.IDX_W(IDX_W), .LANES(LANES), .LANE_W(LANE_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_acc), .wr_idx(word_idx), .wr_lanes(wr_lanes),
        .wr_data(wdata), .wr_par(wr_par),
        .rd_idx(word_idx), .rd_data(st_data), .rd_par(st_par)
    );

    par_lane_gen #(.LANES(LANES), .LANE_W(LANE_W)) u_rgen (
        .data(st_data), .term(addr_term), .par(chk_par)
    );

    assign hit_now = rd_acc & chk_en & in_region & (|(chk_par ^ st_par));

    par_err_track u_flag (
        .clk(clk), .rst_n(rst_n), .hit(hit_now), .clr(clr_flag), .flag(err_flag)
    );

    always_comb begin
        state_d = rd_acc ? ST_RESP : ST_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            rdata_q <= '0;
            hit_q   <= 1'b0;
            lock_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (rd_acc) begin
                rdata_q <= st_data;
                hit_q   <= hit_now;
                lock_q  <= lock;
            end
        end
    end

    always_comb begin
        rdata = rdata_q;
        unique case (state_q)
            ST_IDLE: begin
                rvalid  = 1'b0;
                err_nmi = 1'b0;
                err_brk = 1'b0;
            end
            ST_RESP: begin
                rvalid  = 1'b1;
                err_nmi = hit_q;
                err_brk = hit_q & lock_q;
            end
        endcase
    end

    // R2: every read gets a response in the next cycle
    p_read_resp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_acc |=> rvalid);
    // R2: no response without a read
    p_no_spur_resp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_acc |=> !rvalid);
    // R5: an error pulse only accompanies read data
    p_nmi_with_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
        err_nmi |-> rvalid);
    // R6: disabled checking stays quiet
    p_disabled_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_acc && !chk_en) |=> !err_nmi);
    // R7: outside the protected region no error is reported
    p_region_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_acc && !in_region) |=> !err_nmi);
    // R8: the sticky flag is up whenever the pulse is
    p_flag_with_nmi_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err_nmi |-> err_flag);
    // R9: break needs an error and the lock
    p_brk_needs_nmi_r9: assert property (@(posedge clk) disable iff (!rst_n)
        err_brk |-> err_nmi);
    p_brk_unlocked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_acc && !lock) |=> !err_brk);
endmodule

// File: tb/par_sram_guard_tb.sv
module par_sram_guard_tb;
    localparam int TB_CLK_NS = 10;
    localparam int IDX_W     = 4;
    localparam int PROT      = 8;
    localparam int NWORDS    = 1 << IDX_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req = 1'b0, we = 1'b0;
    logic [1:0]        size = 2'd2;
    logic [IDX_W+1:0]  addr = '0;
    logic [31:0]       wdata = '0;
    logic              chk_en = 1'b0, bypass = 1'b0, lock = 1'b0, clr_flag = 1'b0;
    logic [31:0]       rdata;
    logic              rvalid, err_nmi, err_brk, err_flag;

    int n_chk = 0;
    int n_bad = 0;

    logic [7:0] mb [NWORDS][4];
    logic       mt [NWORDS][4];
    logic       fl;

    always #(TB_CLK_NS/2) clk = ~clk;

    par_sram_guard #(.IDX_W(IDX_W), .PROT_WORDS(PROT)) u_dut (
        .clk(clk), .rst_n(rst_n), .req(req), .we(we), .size(size), .addr(addr),
        .wdata(wdata), .chk_en(chk_en), .bypass(bypass), .lock(lock),
        .clr_flag(clr_flag), .rdata(rdata), .rvalid(rvalid), .err_nmi(err_nmi),
        .err_brk(err_brk), .err_flag(err_flag)
    );

    function automatic logic apar(int w);
        logic [IDX_W-1:0] v = IDX_W'(w);
        return ^v;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic do_write(int w, int off, int sz, logic [31:0] d, logic byp);
        logic [3:0] m;
        @(negedge clk);
        req = 1'b1; we = 1'b1; size = 2'(sz); addr = {IDX_W'(w), 2'(off)};
        wdata = d; bypass = byp;
        @(negedge clk);
        req = 1'b0; we = 1'b0;
        if (sz == 0)      m = 4'b0001 << off;
        else if (sz == 1) m = (off >= 2) ? 4'b1100 : 4'b0011;
        else              m = 4'b1111;
        for (int k = 0; k < 4; k++) begin
            if (m[k]) begin
                mb[w][k] = d[8*k +: 8];
                mt[w][k] = byp ? 1'b0 : apar(w);
            end
        end
    endtask

    task automatic do_read(int w, logic byp, logic chk, logic lck, logic clr, string tag);
        logic exp_err;
        logic t;
        logic [31:0] exp_d;
        t = byp ? 1'b0 : apar(w);
        exp_err = 1'b0;
        for (int k = 0; k < 4; k++) begin
            exp_d[8*k +: 8] = mb[w][k];
            if (mt[w][k] != t) exp_err = 1'b1;
        end
        exp_err = exp_err & chk & (w < PROT);
        @(negedge clk);
        req = 1'b1; we = 1'b0; size = 2'd2; addr = {IDX_W'(w), 2'd0};
        bypass = byp; chk_en = chk; lock = lck; clr_flag = clr;
        @(negedge clk);
        req = 1'b0; clr_flag = 1'b0;
        fl = exp_err | (fl & ~clr);
        check({tag, " rvalid"}, 32'(rvalid), 32'd1);
        check({tag, " rdata"}, rdata, exp_d);
        check({tag, " nmi"}, 32'(err_nmi), 32'(exp_err));
        check({tag, " brk R9"}, 32'(err_brk), 32'(exp_err & lck));
        check({tag, " flag R8"}, 32'(err_flag), 32'(fl));
    endtask

    task automatic clear_flag();
        @(negedge clk);
        clr_flag = 1'b1;
        @(negedge clk);
        clr_flag = 1'b0;
        fl = 1'b0;
        check("R8 clear", 32'(err_flag), 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog R2 act=hung exp=done");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        fl = 1'b0;
        for (int w = 0; w < NWORDS; w++)
            for (int k = 0; k < 4; k++) begin
                mb[w][k] = 8'h00;
                mt[w][k] = apar(w);
            end
        repeat (3) @(negedge clk);
        check("R1 rvalid", 32'(rvalid), 32'd0);
        check("R1 nmi", 32'(err_nmi), 32'd0);
        check("R1 brk", 32'(err_brk), 32'd0);
        check("R1 flag", 32'(err_flag), 32'd0);
        rst_n = 1'b1;
        for (int w = 0; w < NWORDS; w++) do_read(w, 1'b0, 1'b1, 1'b1, 1'b0, "R1 init");
        @(negedge clk);
        check("R2 single cycle", 32'(rvalid), 32'd0);

        for (int w = 0; w < NWORDS; w++)
            for (int wb = 0; wb < 2; wb++)
                for (int rb = 0; rb < 2; rb++) begin
                    do_write(w, 0, 2, (32'hA5C3_0F00 ^ (32'(w) * 32'h0101_0101)) + 32'(wb), wb[0]);
                    check("R2 no resp on write", 32'(rvalid), 32'd0);
                    do_read(w, rb[0], 1'b1, 1'b1, 1'b0,
                            (w >= PROT) ? "R7" : ((wb != rb) ? "R5" : "R4"));
                    if (fl) clear_flag();
                end

        do_write(1, 0, 2, 32'h1234_5678, 1'b0);
        do_read(1, 1'b1, 1'b0, 1'b1, 1'b0, "R6 disabled");
        do_read(1, 1'b1, 1'b1, 1'b0, 1'b0, "R9 unlocked");
        do_read(1, 1'b0, 1'b1, 1'b1, 1'b0, "R8 hold");
        do_read(1, 1'b1, 1'b1, 1'b1, 1'b1, "R8 error beats clear");
        clear_flag();

        for (int sz = 0; sz < 3; sz++)
            for (int off = 0; off < 4; off++) begin
                do_write(5, 0, 2, 32'h0000_0000, 1'b0);
                do_write(5, off, sz, 32'hDEAD_BEEF ^ 32'(off * 17 + sz), 1'b0);
                do_read(5, 1'b0, 1'b1, 1'b1, 1'b0, "R3 lanes");
            end

        do_write(7, 0, 2, 32'h7777_7777, 1'b1);
        do_read(7, 1'b0, 1'b1, 1'b1, 1'b0, "R10 base");
        for (int k = 0; k < 4; k++) begin
            do_write(7, k, 0, 32'h1122_3344, 1'b0);
            do_read(7, 1'b0, 1'b1, 1'b1, 1'b0, "R10 partial");
        end
        if (fl) clear_flag();

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule